// File: doc/BRIEF.md
# Processor Reset and Double-Fault Halt Sequencer

This block steers a 32-bit processor out of reset and keeps track of the halted condition that follows a double fault. While the synchronous active-low reset input is held low, the block drops any bus activity in progress and holds its initial state. Anything that was in flight at that moment is abandoned and is not resumed. During that time it also forces the status register, the vector base register and the enables of the directly attached memories to their defined start values.

Once reset is released, the block asks for the bus. After the grant it issues two 32-bit reads. The first read, at the stack vector address, loads the supervisor stack pointer. The second read, at the next word, loads the program counter. The block then pulses a start strobe that tells the core to begin fetching at that program counter. Several conditions send it to a sticky halt:

- an error on either of the two reads;
- a fault before the core reports that its first instruction has completed;
- any fault that arrives while the core is already processing an exception.

Only reset leaves the halt.

Top module: `cpu_reset_seq`

## Requirements
- R1: While `rst_n` is low at a rising edge, `bus_req`, `read_req`, `core_start` and `halted` are all low from the next cycle on. A read in progress is abandoned and is not resumed after reset is released.
- R2: After reset, `sr` reads 0x2700. In that value the supervisor bit (bit 13) is 1, the trace bit (bit 15) is 0, the master bit (bit 12) is 0, and the interrupt mask (bits 10:8) is 7.
- R3: After reset, `vbr` is 0x0000_0000, every bit of `mem_en` is 0, and `ssp` and `pc` are 0.
- R4: One cycle after reset is released, `bus_req` rises. `read_req` stays low until `bus_grant` has been sampled high. The cycle after that sample, `read_req` is high with `read_addr` = 0x0000_0000.
- R5: A `read_valid` on the first read loads `read_data` into `ssp` and moves the read to `read_addr` = 0x0000_0004. A `read_valid` on the second read loads `pc`, and `core_start` is high for exactly the next cycle.
- R6: A `read_err` on either reset read sets `halted` in the next cycle, and `core_start` never pulses.
- R7: Between `core_start` and `first_insn_done`, any `fault_in` sets `halted` in the next cycle.
- R8: After `first_insn_done`, a `fault_in` with `exc_active` low has no effect on `halted`. A `fault_in` with `exc_active` high sets `halted` in the next cycle.
- R9: Once set, `halted` stays high whatever the other inputs do, until reset. Reset clears it and starts the fetch sequence again.
- R10: Each read waits any number of cycles for its response, keeping `read_req`, `read_addr` and `bus_req` steady while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset request |
| bus_grant | input | 1 | Bus granted to the sequencer |
| read_valid | input | 1 | Read data valid |
| read_data | input | 32 | Read data |
| read_err | input | 1 | Access or address error on the current read |
| first_insn_done | input | 1 | Core completed its first instruction |
| fault_in | input | 1 | Core reports an access or address fault |
| exc_active | input | 1 | Core is processing an exception |
| bus_req | output | 1 | Bus request |
| read_req | output | 1 | Read request |
| read_addr | output | 32 | Read address |
| sr | output | 16 | Status register |
| vbr | output | 32 | Vector base register |
| ssp | output | 32 | Supervisor stack pointer |
| pc | output | 32 | Program counter |
| mem_en | output | 2 | Enables of directly attached memories |
| core_start | output | 1 | One-cycle start-fetch pulse |
| halted | output | 1 | Double-fault halt state |

## Verification
Every output of the block is registered, so each response is due exactly one rising edge after the input that causes it is sampled. This applies to `bus_req` after reset release, the first read after the grant, the second read and the `ssp` load after the first valid, `core_start` and `pc` after the second valid, and `halted` after an error or fault. The bench drives each input on a falling edge and holds it through one rising edge. It compares the outputs at the following falling edge, which is the first point where the new value is settled. Waiting phases are checked on every intervening cycle, so an early response is caught as well as a late one.

// File: rtl/rst_seq_pkg.sv
// Package: shared state encoding and status-register layout for the reset
// sequencer. Assumes a 16-bit status register with supervisor, trace, master
// and interrupt-mask fields at the positions the core decodes.
package rst_seq_pkg;

    typedef enum logic [2:0] {
        SQ_RESET,
        SQ_BUSREQ,
        SQ_RD_SP,
        SQ_RD_PC,
        SQ_START,
        SQ_WINDOW,
        SQ_RUN,
        SQ_HALT
    } seq_state_t;

    localparam int SR_W       = 16;
    localparam int SR_T_BIT   = 15;
    localparam int SR_S_BIT   = 13;
    localparam int SR_M_BIT   = 12;
    localparam int SR_IPL_LSB = 8;
    localparam int SR_IPL_W   = 3;

    // Builds the status word the core sees right after reset.
    function automatic logic [SR_W-1:0] sr_reset_value();
        logic [SR_W-1:0] v;
        v = '0;
        v[SR_S_BIT] = 1'b1;
        v[SR_T_BIT] = 1'b0;
        v[SR_M_BIT] = 1'b0;
        v[SR_IPL_LSB +: SR_IPL_W] = '1;
        return v;
    endfunction

endpackage

// File: rtl/rst_seq_fsm.sv
// Module: control state machine of the reset sequencer. It walks through the
// bus request, the two vector reads and the start pulse, and then watches for
// faults that force the sticky halt. Assumes that all inputs are synchronous to
// clk and that rst_n is sampled synchronously (active low).
module rst_seq_fsm
    import rst_seq_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter logic [ADDR_W-1:0] SP_ADDR = '0,
    parameter int WORD_BYTES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_grant,
    input  logic              read_valid,
    input  logic              read_err,
    input  logic              first_insn_done,
    input  logic              fault_in,
    input  logic              exc_active,
    output logic              bus_req,
    output logic              read_req,
    output logic [ADDR_W-1:0] read_addr,
    output logic              ssp_load,
    output logic              pc_load,
    output logic              core_start,
    output logic              halted
);

    localparam logic [ADDR_W-1:0] PC_ADDR = SP_ADDR + ADDR_W'(WORD_BYTES);

    seq_state_t state_q, state_d;

    // Next-state decision: error and fault checks take priority over progress.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_RESET:  state_d = SQ_BUSREQ;
            SQ_BUSREQ: if (bus_grant) state_d = SQ_RD_SP;
            SQ_RD_SP:  if (read_err) state_d = SQ_HALT;
                       else if (read_valid) state_d = SQ_RD_PC;
            SQ_RD_PC:  if (read_err) state_d = SQ_HALT;
                       else if (read_valid) state_d = SQ_START;
            SQ_START:  state_d = fault_in ? SQ_HALT : SQ_WINDOW;
            SQ_WINDOW: if (fault_in) state_d = SQ_HALT;
                       else if (first_insn_done) state_d = SQ_RUN;
            SQ_RUN:    if (fault_in && exc_active) state_d = SQ_HALT;
            SQ_HALT:   state_d = SQ_HALT;
            default:   state_d = SQ_RESET;
        endcase
    end

    // State register: reset aborts whatever step is in progress.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= SQ_RESET;
        else        state_q <= state_d;
    end

    // Output decode from the registered state.
    always_comb begin
        read_req   = (state_q == SQ_RD_SP) || (state_q == SQ_RD_PC);
        bus_req    = read_req || (state_q == SQ_BUSREQ);
        read_addr  = (state_q == SQ_RD_PC) ? PC_ADDR : SP_ADDR;
        core_start = (state_q == SQ_START);
        halted     = (state_q == SQ_HALT);
        ssp_load   = (state_q == SQ_RD_SP) && read_valid && !read_err;
        pc_load    = (state_q == SQ_RD_PC) && read_valid && !read_err;
    end

    AST_RESET_RELEASES_BUS: assert property (@(posedge clk)
        !rst_n |=> (!bus_req && !read_req && !halted && !core_start)); // R1
    AST_PC_FOLLOWS_SP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(state_q == SQ_RD_PC) |-> $past(state_q == SQ_RD_SP) && $past(read_valid)); // R5
    AST_START_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        core_start |=> !core_start); // R5
    AST_READ_ERR_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (read_req && read_err) |=> halted); // R6
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted); // R9
    AST_WAIT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (read_req && !read_valid && !read_err) |=> (read_req && $stable(read_addr))); // R10

endmodule

// File: rtl/rst_seq_regs.sv
// Module: architectural registers that the reset sequence initializes or loads:
// status, vector base, supervisor stack pointer, program counter and the
// attached-memory enables. Assumes the load strobes come from the sequencer FSM.
module rst_seq_regs
    import rst_seq_pkg::*;
#(
    parameter int DATA_W  = 32,
    parameter int NUM_MEM = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ssp_load,
    input  logic              pc_load,
    input  logic [DATA_W-1:0] read_data,
    output logic [SR_W-1:0]   sr,
    output logic [DATA_W-1:0] vbr,
    output logic [DATA_W-1:0] ssp,
    output logic [DATA_W-1:0] pc,
    output logic [NUM_MEM-1:0] mem_en
);

    // Status and vector base: forced to defined values on reset, held otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= sr_reset_value();
            vbr <= '0;
        end else begin
            sr  <= sr;
            vbr <= vbr;
        end
    end

    // Stack pointer and program counter: cleared on reset, loaded from vector reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ssp <= '0;
            pc  <= '0;
        end else begin
            if (ssp_load) ssp <= read_data;
            if (pc_load)  pc  <= read_data;
        end
    end

    // One enable flop per directly attached memory, disabled by reset.
    for (genvar g = 0; g < NUM_MEM; g++) begin : g_mem
        logic en_q;
        always_ff @(posedge clk) begin
            if (!rst_n) en_q <= 1'b0;
            else        en_q <= en_q;
        end
        assign mem_en[g] = en_q;
    end

    AST_SR_AFTER_RESET: assert property (@(posedge clk)
        $past(!rst_n) |-> (sr[SR_S_BIT] && !sr[SR_T_BIT] && !sr[SR_M_BIT]
                           && (&sr[SR_IPL_LSB +: SR_IPL_W]))); // R2
    AST_MEM_OFF_AFTER_RESET: assert property (@(posedge clk)
        $past(!rst_n) |-> (mem_en == '0 && vbr == '0)); // R3

endmodule

// File: rtl/cpu_reset_seq.sv
// Module: top of the processor reset and double-fault halt sequencer. It joins
// the control FSM and the architectural register block. Assumes a single clock
// domain and a synchronous active-low reset.
module cpu_reset_seq
    import rst_seq_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int NUM_MEM = 2,
    parameter logic [ADDR_W-1:0] SP_VEC_ADDR = '0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               bus_grant,
    input  logic               read_valid,
    input  logic [DATA_W-1:0]  read_data,
    input  logic               read_err,
    input  logic               first_insn_done,
    input  logic               fault_in,
    input  logic               exc_active,
    output logic               bus_req,
    output logic               read_req,
    output logic [ADDR_W-1:0]  read_addr,
    output logic [15:0]        sr,
    output logic [DATA_W-1:0]  vbr,
    output logic [DATA_W-1:0]  ssp,
    output logic [DATA_W-1:0]  pc,
    output logic [NUM_MEM-1:0] mem_en,
    output logic               core_start,
    output logic               halted
);

    localparam int WORD_BYTES = DATA_W / 8;

    logic ssp_load, pc_load;

    rst_seq_fsm #(
        .ADDR_W     (ADDR_W),
        .SP_ADDR    (SP_VEC_ADDR),
        .WORD_BYTES (WORD_BYTES)
    ) u_fsm (
        .clk             (clk),
        .rst_n           (rst_n),
        .bus_grant       (bus_grant),
        .read_valid      (read_valid),
        .read_err        (read_err),
        .first_insn_done (first_insn_done),
        .fault_in        (fault_in),
        .exc_active      (exc_active),
        .bus_req         (bus_req),
        .read_req        (read_req),
        .read_addr       (read_addr),
        .ssp_load        (ssp_load),
        .pc_load         (pc_load),
        .core_start      (core_start),
        .halted          (halted)
    );

    rst_seq_regs #(
        .DATA_W  (DATA_W),
        .NUM_MEM (NUM_MEM)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .ssp_load  (ssp_load),
        .pc_load   (pc_load),
        .read_data (read_data),
        .sr        (sr),
        .vbr       (vbr),
        .ssp       (ssp),
        .pc        (pc),
        .mem_en    (mem_en)
    );

    AST_WINDOW_FAULT_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
        (core_start && fault_in) |=> halted); // R7

endmodule

// File: tb/sim_cpu_reset_seq.sv
module sim_cpu_reset_seq;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [31:0] sp;
        logic [31:0] pcv;
        logic [3:0]  wsp;
        logic [3:0]  wpc;
        logic [1:0]  err;   // 0 none, 1 on stack read, 2 on pc read
        logic [1:0]  act;   // 0 idle, 1 fault in window, 2 done then faults
    } vec_t;

    localparam int NV = 5;
    localparam vec_t VEC [NV] = '{
        '{32'h2000_1000, 32'h0000_0400, 4'd0, 4'd0, 2'd0, 2'd0},
        '{32'h0001_FFF0, 32'h0000_8008, 4'd3, 4'd5, 2'd0, 2'd1},
        '{32'hDEAD_BEE0, 32'h1234_5678, 4'd1, 4'd0, 2'd0, 2'd2},
        '{32'h0000_0001, 32'h0000_0002, 4'd2, 4'd0, 2'd1, 2'd0},
        '{32'h3000_0000, 32'h0000_0000, 4'd0, 4'd4, 2'd2, 2'd0}
    };

    logic clk = 0;
    logic rst_n = 0, bus_grant = 0, read_valid = 0, read_err = 0;
    logic first_insn_done = 0, fault_in = 0, exc_active = 0;
    logic [31:0] read_data = 0;
    logic bus_req, read_req, core_start, halted;
    logic [31:0] read_addr, vbr, ssp, pc;
    logic [15:0] sr;
    logic [1:0] mem_en;
    int checks = 0, failures = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cpu_reset_seq u0 (
        .clk(clk), .rst_n(rst_n), .bus_grant(bus_grant), .read_valid(read_valid),
        .read_data(read_data), .read_err(read_err), .first_insn_done(first_insn_done),
        .fault_in(fault_in), .exc_active(exc_active), .bus_req(bus_req),
        .read_req(read_req), .read_addr(read_addr), .sr(sr), .vbr(vbr), .ssp(ssp),
        .pc(pc), .mem_en(mem_en), .core_start(core_start), .halted(halted)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 0; bus_grant = 0; read_valid = 0; read_err = 0;
        first_insn_done = 0; fault_in = 0; exc_active = 0;
        tick(); tick();
        chk("R1 outputs in reset", {28'd0, bus_req, read_req, core_start, halted}, 32'd0);
        chk("R2 sr reset", {16'd0, sr}, 32'h0000_2700);
        chk("R3 vbr reset", vbr, 32'd0);
        chk("R3 mem_en reset", {30'd0, mem_en}, 32'd0);
        chk("R3 ssp/pc reset", ssp | pc, 32'd0);
        rst_n = 1;
        tick();
        chk("R4 bus_req after release", {30'd0, bus_req, read_req}, 32'd2);
    endtask

    task automatic grant_bus();
        tick();
        chk("R4 no read before grant", {31'd0, read_req}, 32'd0);
        bus_grant = 1; tick(); bus_grant = 0;
        chk("R4 first read addr", read_addr, 32'h0);
        chk("R4 first read_req", {31'd0, read_req}, 32'd1);
    endtask

    task automatic wait_cycles(input int n, input logic [31:0] addr);
        for (int i = 0; i < n; i++) begin
            tick();
            chk("R10 wait steady", {read_addr[30:0], bus_req & read_req}, {addr[30:0], 1'b1});
        end
    endtask

    task automatic run_vec(input vec_t v);
        do_reset();
        grant_bus();
        wait_cycles(int'(v.wsp), 32'h0);
        if (v.err == 2'd1) begin
            read_err = 1; tick(); read_err = 0;
            chk("R6 err on stack read", {30'd0, halted, core_start}, 32'd2);
            tick();
            chk("R9 halt held", {31'd0, halted}, 32'd1);
            return;
        end
        read_data = v.sp; read_valid = 1; tick(); read_valid = 0; read_data = '0;
        chk("R5 ssp loaded", ssp, v.sp);
        chk("R5 second read addr", read_addr, 32'h4);
        wait_cycles(int'(v.wpc), 32'h4);
        if (v.err == 2'd2) begin
            read_err = 1; tick(); read_err = 0;
            chk("R6 err on pc read", {30'd0, halted, core_start}, 32'd2);
            tick();
            chk("R6 no start after err", {31'd0, core_start}, 32'd0);
            return;
        end
        read_data = v.pcv; read_valid = 1; tick(); read_valid = 0; read_data = '0;
        chk("R5 core_start pulse", {31'd0, core_start}, 32'd1);
        chk("R5 pc loaded", pc, v.pcv);
        chk("R5 bus released", {31'd0, bus_req}, 32'd0);
        tick();
        chk("R5 core_start one cycle", {31'd0, core_start}, 32'd0);
        if (v.act == 2'd1) begin
            fault_in = 1; tick(); fault_in = 0;
            chk("R7 fault in window halts", {31'd0, halted}, 32'd1);
        end else if (v.act == 2'd2) begin
            first_insn_done = 1; tick(); first_insn_done = 0;
            fault_in = 1; tick();
            chk("R8 plain fault ignored", {31'd0, halted}, 32'd0);
            exc_active = 1; tick(); fault_in = 0; exc_active = 0;
            chk("R8 fault during exception halts", {31'd0, halted}, 32'd1);
        end else begin
            tick();
            chk("R5 running not halted", {31'd0, halted}, 32'd0);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        @(negedge clk);
        for (int i = 0; i < NV; i++) run_vec(VEC[i]);

        // R9: halted stays set whatever the inputs do, until reset clears it.
        for (int i = 0; i < 4; i++) begin
            bus_grant = 1; read_valid = 1; first_insn_done = 1; fault_in = i[0];
            tick();
            chk("R9 halt sticky", {31'd0, halted}, 32'd1);
        end
        bus_grant = 0; read_valid = 0; first_insn_done = 0; fault_in = 0;
        do_reset();
        chk("R9 reset clears halt", {31'd0, halted}, 32'd0);

        // R1: reset in the middle of the pc read aborts it; the sequence restarts.
        grant_bus();
        read_data = 32'hAAAA_5555; read_valid = 1; tick(); read_valid = 0;
        chk("R1 mid-sequence ssp", ssp, 32'hAAAA_5555);
        rst_n = 0; tick();
        chk("R1 abort drops bus", {30'd0, bus_req, read_req}, 32'd0);
        chk("R1 abort clears ssp", ssp, 32'd0);
        rst_n = 1; tick();
        chk("R1 restart from bus request", {30'd0, bus_req, read_req}, 32'd2);
        grant_bus();
        chk("R1 restart at stack address", read_addr, 32'h0);

        // R7: a fault in the same cycle as the start pulse is still in the window.
        read_data = 32'h10; read_valid = 1; tick();
        read_data = 32'h20; tick(); read_valid = 0;
        chk("R7 start reached", {31'd0, core_start}, 32'd1);
        fault_in = 1; tick(); fault_in = 0;
        chk("R7 fault on start cycle halts", {31'd0, halted}, 32'd1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule